// File: doc/BRIEF.md
# Queued Interrupt Entry Sequencer

This block controls how a 16-bit stack-based processor core enters and leaves interrupt handlers. It receives two kinds of interrupt request: a software request that carries a message word, and a hardware request from a device that also carries a message. Each request is either taken at once or stored in a circular message queue. A taken interrupt runs a fixed four-step entry sequence. The block drives this sequence as stack-memory writes and register-update strobes toward the core's datapath. A return request runs the matching two-step pop sequence.

The core supplies its current PC, A, SP and handler-address register values, plus a queuing-enable control. It also supplies an instruction-boundary signal, and the block may start a queued interrupt only while that signal is high. Stack memory is read combinationally: read data must be valid in the same cycle as the request. Pushes predecrement SP and write at the new SP. Pops read at SP and then increment it. All register values are captured when a sequence starts, so the core may change its inputs while the sequence runs.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy_o, qen_o and ovf_o are low and no memory or register strobe is asserted.
- R2: While hnd_i is zero, software and hardware requests are dropped: nothing is taken and nothing is queued.
- R3: An accepted entry runs four steps, one per cycle, starting the cycle after the request. Step 1 writes PC to address SP-1 and writes SP-1 to SP. Step 2 loads the PC with the handler address. Step 3 writes A to address SP-2 and writes SP-2 to SP. Step 4 loads A with the message. All values are the ones captured when the entry was accepted.
- R4: Starting an entry sets qen_o, and qen_o stays high through the whole entry.
- R5: A hardware request is always queued and never taken directly. A software request is also queued, instead of taken, when qen_o is high or the sequencer is busy.
- R6: A queued message is taken only when the sequencer is idle, qen_o is low, boundary_i is high and the queue is not empty. Queued messages are taken oldest first.
- R7: A return request clears qen_o and runs two steps. Step 1 reads address SP, loads A with the read data and writes SP+1 to SP. Step 2 reads address SP+1, loads the PC with the read data and writes SP+2 to SP.
- R8: With queue pointer width QW, the queue holds at most 2^QW-1 messages. An insert into a full queue is refused, and the messages already stored are kept in order. A refused insert sets ovf_o, which stays high until reset.
- R9: When the sequencer is idle and no sequence starts, qen_set_i loads qen_o with qen_val_i.
- R10: A queued message that is dispatched while hnd_i is zero is removed from the queue and discarded. No entry starts.
- R11: When software and hardware requests are both queued in the same cycle, the software message is stored ahead of the hardware message.
- R12: busy_o is high for exactly four cycles for an entry and exactly two cycles for a return. A return request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Current program counter |
| a_i | input | 16 | Current A register |
| sp_i | input | 16 | Current stack pointer |
| hnd_i | input | 16 | Handler address register; zero disables interrupts |
| sw_req_i | input | 1 | Software interrupt request strobe |
| sw_msg_i | input | 16 | Software interrupt message |
| hw_req_i | input | 1 | Hardware interrupt request strobe |
| hw_msg_i | input | 16 | Hardware interrupt message |
| ret_req_i | input | 1 | Return-from-interrupt request |
| qen_set_i | input | 1 | Load strobe for the queuing-enable flag |
| qen_val_i | input | 1 | Value loaded into the queuing-enable flag |
| boundary_i | input | 1 | High at an instruction boundary |
| mem_rdata_i | input | 16 | Stack read data, valid in the same cycle as the request |
| mem_req_o | output | 1 | Stack memory access request |
| mem_we_o | output | 1 | Stack access is a write |
| mem_addr_o | output | 16 | Stack access address |
| mem_wdata_o | output | 16 | Stack write data |
| pc_we_o | output | 1 | PC update strobe |
| pc_wdata_o | output | 16 | New PC value |
| a_we_o | output | 1 | A update strobe |
| a_wdata_o | output | 16 | New A value |
| sp_we_o | output | 1 | SP update strobe |
| sp_wdata_o | output | 16 | New SP value |
| busy_o | output | 1 | A sequence is in progress |
| qen_o | output | 1 | Queuing-enable flag |
| ovf_o | output | 1 | Sticky queue-overflow flag |

## Verification
The bench builds the block with QW=3, which gives an 8-slot queue that holds seven messages. With that size, filling the queue to capacity, refusing the next insert and draining every entry in order can each be driven completely in a few dozen cycles. The data width stays at 16 bits. This keeps the stack-pointer wrap-around within reach: the bench uses SP values of zero and one, and the entry addresses wrap below zero. Pop read data is generated as a fixed function of the address, so every popped value can be predicted arithmetically.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_LOAD_PC,
    ST_PUSH_A,
    ST_LOAD_A,
    ST_POP_A,
    ST_POP_PC
  } seq_st_e;
endpackage

// File: rtl/irq_msg_queue.sv
module irq_msg_queue #(
  parameter int DW = 16,
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_a_i,
  input  logic [DW-1:0] data_a_i,
  input  logic          push_b_i,
  input  logic [DW-1:0] data_b_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          ovf_o
);
  localparam int DEPTH = 1 << QW;
  localparam logic [QW-1:0] CAP = QW'(DEPTH - 1);

  logic [DW-1:0] slot_q [DEPTH];
  logic [QW-1:0] wr_ptr_q, rd_ptr_q;
  logic [QW-1:0] used, free_cnt, wr_ptr_b;
  logic          acc_a, acc_b;

  assign used     = wr_ptr_q - rd_ptr_q;
  assign free_cnt = CAP - used;
  assign empty_o  = (used == '0);
  assign head_o   = slot_q[rd_ptr_q];

  // port a has precedence for the free slots
  assign acc_a    = push_a_i && (free_cnt != '0);
  assign acc_b    = push_b_i && (free_cnt > QW'(acc_a));
  assign wr_ptr_b = wr_ptr_q + QW'(acc_a);

  always_ff @(posedge clk_i) begin
    if (acc_a) slot_q[wr_ptr_q] <= data_a_i;
    if (acc_b) slot_q[wr_ptr_b] <= data_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_o    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_q + QW'(acc_a) + QW'(acc_b);
      if (pop_i) rd_ptr_q <= rd_ptr_q + QW'(1);
      if ((push_a_i && !acc_a) || (push_b_i && !acc_b)) ovf_o <= 1'b1;
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);  // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovf_o) |-> ovf_o);  // R8
endmodule

// File: rtl/irq_req_route.sv
module irq_req_route (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_req_i,
  input  logic hw_req_i,
  input  logic ret_req_i,
  input  logic qen_set_i,
  input  logic qen_val_i,
  input  logic boundary_i,
  input  logic hnd_zero_i,
  input  logic idle_i,
  input  logic q_empty_i,
  output logic sw_take_o,
  output logic sw_queue_o,
  output logic hw_queue_o,
  output logic ret_go_o,
  output logic pop_o,
  output logic disp_take_o,
  output logic qen_o
);
  logic sw_v, hw_v, disp_go, qen_q;

  assign sw_v     = sw_req_i && !hnd_zero_i;
  assign hw_v     = hw_req_i && !hnd_zero_i;
  assign ret_go_o = ret_req_i && idle_i;

  // queued work goes first at a boundary
  assign disp_go     = idle_i && !qen_q && boundary_i && !q_empty_i && !ret_go_o;
  assign pop_o       = disp_go;
  assign disp_take_o = disp_go && !hnd_zero_i;

  assign sw_take_o  = sw_v && idle_i && !qen_q && !ret_go_o && !disp_go;
  assign sw_queue_o = sw_v && !sw_take_o;
  assign hw_queue_o = hw_v;
  assign qen_o      = qen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        qen_q <= 1'b0;
    else if (sw_take_o || disp_take_o)  qen_q <= 1'b1;
    else if (ret_go_o)                  qen_q <= 1'b0;
    else if (qen_set_i && idle_i)       qen_q <= qen_val_i;
  end

  AST_QEN_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_take_o || disp_take_o) |=> qen_o);  // R4
  AST_QEN_AFTER_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_go_o |=> !qen_o);  // R7
  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sw_take_o, disp_take_o, ret_go_o}));  // R12
endmodule

// File: rtl/irq_stack_fsm.sv
module irq_stack_fsm
  import irq_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_entry_i,
  input  logic [DW-1:0] entry_msg_i,
  input  logic          start_ret_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] hnd_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          idle_o,
  output logic          entry_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pc_we_o,
  output logic [DW-1:0] pc_wdata_o,
  output logic          a_we_o,
  output logic [DW-1:0] a_wdata_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_wdata_o
);
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] TWO = DW'(2);

  seq_st_e       st_q, st_d;
  logic [DW-1:0] pc_q, a_q, sp_q, hnd_q, msg_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_entry_i)    st_d = ST_PUSH_PC;
        else if (start_ret_i) st_d = ST_POP_A;
      end
      ST_PUSH_PC: st_d = ST_LOAD_PC;
      ST_LOAD_PC: st_d = ST_PUSH_A;
      ST_PUSH_A:  st_d = ST_LOAD_A;
      ST_LOAD_A:  st_d = ST_IDLE;
      ST_POP_A:   st_d = ST_POP_PC;
      ST_POP_PC:  st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // capture context at sequence start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      a_q   <= '0;
      sp_q  <= '0;
      hnd_q <= '0;
      msg_q <= '0;
    end else if (st_q == ST_IDLE && (start_entry_i || start_ret_i)) begin
      pc_q  <= pc_i;
      a_q   <= a_i;
      sp_q  <= sp_i;
      hnd_q <= hnd_i;
      msg_q <= entry_msg_i;
    end
  end

  assign idle_o  = (st_q == ST_IDLE);
  assign entry_o = (st_q == ST_PUSH_PC) || (st_q == ST_LOAD_PC) ||
                   (st_q == ST_PUSH_A)  || (st_q == ST_LOAD_A);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    pc_we_o     = 1'b0;
    pc_wdata_o  = '0;
    a_we_o      = 1'b0;
    a_wdata_o   = '0;
    sp_we_o     = 1'b0;
    sp_wdata_o  = '0;
    unique case (st_q)
      ST_PUSH_PC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - ONE;
        mem_wdata_o = pc_q;
        sp_we_o     = 1'b1;
        sp_wdata_o  = sp_q - ONE;
      end
      ST_LOAD_PC: begin
        pc_we_o    = 1'b1;
        pc_wdata_o = hnd_q;
      end
      ST_PUSH_A: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - TWO;
        mem_wdata_o = a_q;
        sp_we_o     = 1'b1;
        sp_wdata_o  = sp_q - TWO;
      end
      ST_LOAD_A: begin
        a_we_o    = 1'b1;
        a_wdata_o = msg_q;
      end
      ST_POP_A: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sp_q;
        a_we_o     = 1'b1;
        a_wdata_o  = mem_rdata_i;
        sp_we_o    = 1'b1;
        sp_wdata_o = sp_q + ONE;
      end
      ST_POP_PC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sp_q + ONE;
        pc_we_o    = 1'b1;
        pc_wdata_o = mem_rdata_i;
        sp_we_o    = 1'b1;
        sp_wdata_o = sp_q + TWO;
      end
      default: ;
    endcase
  end

  AST_PC_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD_PC) |-> (pc_wdata_o != '0));  // R2
  AST_PUSH_BEFORE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD_PC) |-> $past(mem_we_o));  // R3
  AST_PUSH_DESCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PUSH_A) |-> (mem_addr_o == $past(mem_addr_o, 2) - ONE));  // R3
  AST_POP_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_POP_PC) |-> (mem_addr_o == $past(mem_addr_o) + ONE));  // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pc_we_o, a_we_o, mem_we_o}));  // R12
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_entry_i || start_ret_i) |-> idle_o);  // R12
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DW = 16,
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] hnd_i,
  input  logic          sw_req_i,
  input  logic [DW-1:0] sw_msg_i,
  input  logic          hw_req_i,
  input  logic [DW-1:0] hw_msg_i,
  input  logic          ret_req_i,
  input  logic          qen_set_i,
  input  logic          qen_val_i,
  input  logic          boundary_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pc_we_o,
  output logic [DW-1:0] pc_wdata_o,
  output logic          a_we_o,
  output logic [DW-1:0] a_wdata_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_wdata_o,
  output logic          busy_o,
  output logic          qen_o,
  output logic          ovf_o
);
  logic          idle, in_entry, q_empty, pop;
  logic          sw_take, sw_queue, hw_queue, ret_go, disp_take;
  logic [DW-1:0] q_head, entry_msg;

  irq_req_route u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_req_i    (sw_req_i),
    .hw_req_i    (hw_req_i),
    .ret_req_i   (ret_req_i),
    .qen_set_i   (qen_set_i),
    .qen_val_i   (qen_val_i),
    .boundary_i  (boundary_i),
    .hnd_zero_i  (hnd_i == '0),
    .idle_i      (idle),
    .q_empty_i   (q_empty),
    .sw_take_o   (sw_take),
    .sw_queue_o  (sw_queue),
    .hw_queue_o  (hw_queue),
    .ret_go_o    (ret_go),
    .pop_o       (pop),
    .disp_take_o (disp_take),
    .qen_o       (qen_o)
  );

  irq_msg_queue #(.DW(DW), .QW(QW)) u_queue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_a_i (sw_queue),
    .data_a_i (sw_msg_i),
    .push_b_i (hw_queue),
    .data_b_i (hw_msg_i),
    .pop_i    (pop),
    .head_o   (q_head),
    .empty_o  (q_empty),
    .ovf_o    (ovf_o)
  );

  assign entry_msg = sw_take ? sw_msg_i : q_head;

  irq_stack_fsm #(.DW(DW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_entry_i (sw_take || disp_take),
    .entry_msg_i   (entry_msg),
    .start_ret_i   (ret_go),
    .pc_i          (pc_i),
    .a_i           (a_i),
    .sp_i          (sp_i),
    .hnd_i         (hnd_i),
    .mem_rdata_i   (mem_rdata_i),
    .idle_o        (idle),
    .entry_o       (in_entry),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .pc_we_o       (pc_we_o),
    .pc_wdata_o    (pc_wdata_o),
    .a_we_o        (a_we_o),
    .a_wdata_o     (a_wdata_o),
    .sp_we_o       (sp_we_o),
    .sp_wdata_o    (sp_wdata_o)
  );

  assign busy_o = !idle;

  AST_QEN_DURING_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_entry |-> qen_o);  // R4
  AST_HW_NEVER_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_req_i && idle && !sw_take && !disp_take && !ret_go) |=> !busy_o);  // R5
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int DW = 16;
  localparam int QW = 3;
  localparam int CAPN = (1 << QW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] pc_i = '0, a_i = '0, sp_i = '0, hnd_i = '0;
  logic sw_req = 0, hw_req = 0, ret_req = 0, qen_set = 0, qen_val = 0, boundary = 0;
  logic [15:0] sw_msg = '0, hw_msg = '0;
  logic [15:0] mem_rdata;
  logic mem_req, mem_we, pc_we, a_we, sp_we, busy, qen, ovf;
  logic [15:0] mem_addr, mem_wdata, pc_wdata, a_wdata, sp_wdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_q [16];

  localparam logic [15:0] P0 = 16'h2468, A0 = 16'h0A0A, S0 = 16'h8000, H0 = 16'h0400;

  always #4 clk = ~clk;
  assign mem_rdata = mem_addr ^ 16'h5A5A;

  irq_entry_seq #(.DW(DW), .QW(QW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc_i), .a_i(a_i), .sp_i(sp_i), .hnd_i(hnd_i),
    .sw_req_i(sw_req), .sw_msg_i(sw_msg), .hw_req_i(hw_req), .hw_msg_i(hw_msg),
    .ret_req_i(ret_req), .qen_set_i(qen_set), .qen_val_i(qen_val), .boundary_i(boundary),
    .mem_rdata_i(mem_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .pc_we_o(pc_we), .pc_wdata_o(pc_wdata), .a_we_o(a_we),
    .a_wdata_o(a_wdata), .sp_we_o(sp_we), .sp_wdata_o(sp_wdata), .busy_o(busy),
    .qen_o(qen), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] strobes();
    return {mem_req, mem_we, pc_we, a_we, sp_we};
  endfunction

  // current cycle must be push-PC step
  task automatic expect_entry(input logic [15:0] p, a, s, h, m, input string tag);
    chk({tag, " R3 step1 strobes"}, strobes(), 5'b11001);
    chk({tag, " R3 step1 addr"}, mem_addr, 16'(s - 16'd1));
    chk({tag, " R3 step1 data"}, mem_wdata, p);
    chk({tag, " R3 step1 sp"}, sp_wdata, 16'(s - 16'd1));
    chk({tag, " R12 busy"}, busy, 1'b1);
    tick;
    chk({tag, " R3 step2 strobes"}, strobes(), 5'b00100);
    chk({tag, " R3 step2 pc"}, pc_wdata, h);
    chk({tag, " R4 qen in entry"}, qen, 1'b1);
    tick;
    chk({tag, " R3 step3 strobes"}, strobes(), 5'b11001);
    chk({tag, " R3 step3 addr"}, mem_addr, 16'(s - 16'd2));
    chk({tag, " R3 step3 data"}, mem_wdata, a);
    chk({tag, " R3 step3 sp"}, sp_wdata, 16'(s - 16'd2));
    tick;
    chk({tag, " R3 step4 strobes"}, strobes(), 5'b00010);
    chk({tag, " R3 step4 a"}, a_wdata, m);
    chk({tag, " R12 busy step4"}, busy, 1'b1);
  endtask

  task automatic expect_return(input logic [15:0] s, input string tag);
    chk({tag, " R7 pop1 strobes"}, strobes(), 5'b10011);
    chk({tag, " R7 pop1 addr"}, mem_addr, s);
    chk({tag, " R7 pop1 a"}, a_wdata, s ^ 16'h5A5A);
    chk({tag, " R7 pop1 sp"}, sp_wdata, 16'(s + 16'd1));
    chk({tag, " R7 qen cleared"}, qen, 1'b0);
    tick;
    chk({tag, " R7 pop2 strobes"}, strobes(), 5'b10101);
    chk({tag, " R7 pop2 addr"}, mem_addr, 16'(s + 16'd1));
    chk({tag, " R7 pop2 pc"}, pc_wdata, 16'(s + 16'd1) ^ 16'h5A5A);
    chk({tag, " R7 pop2 sp"}, sp_wdata, 16'(s + 16'd2));
  endtask

  task automatic do_return(input string tag);
    ret_req = 1;
    tick;
    ret_req = 0;
    expect_return(sp_i, tag);
    tick;
    chk({tag, " R12 idle after return"}, busy, 1'b0);
  endtask

  // idle, qen high, n messages in exp_q; R6 drain in order
  task automatic drain(input int n, input string tag);
    qen_set = 1; qen_val = 0;
    tick;
    qen_set = 0;
    chk({tag, " R9 qen cleared"}, qen, 1'b0);
    tick;
    chk({tag, " R6 no dispatch off boundary"}, busy, 1'b0);
    boundary = 1;
    tick;
    for (int k = 0; k < n; k++) begin
      expect_entry(P0, A0, S0, H0, exp_q[k], {tag, " R6 dispatch"});
      tick;
      ret_req = 1;
      tick;
      ret_req = 0;
      expect_return(S0, tag);
      tick;
      if (k < n - 1) tick;
    end
    tick;
    chk({tag, " R6 queue drained"}, busy, 1'b0);
    boundary = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    pc_i = P0; a_i = A0; sp_i = S0; hnd_i = H0;
    tick; tick;
    rst_ni = 1;
    chk("R1 busy", busy, 1'b0);
    chk("R1 qen", qen, 1'b0);
    chk("R1 ovf", ovf, 1'b0);
    chk("R1 strobes", strobes(), 5'b00000);

    // direct entry/return sweep
    for (int i = 0; i < 8; i++) begin
      logic [15:0] p, a, s, h, m;
      p = 16'(16'h1000 + i * 16'h1111);
      a = 16'(16'h0F0F ^ (i * 16'h0321));
      s = (i == 0) ? 16'h0000 : (i == 1) ? 16'h0001 : 16'(i * 16'h2345);
      h = 16'(16'h0100 + i * 3);
      m = 16'hF000 ^ 16'(i);
      pc_i = p; a_i = a; sp_i = s; hnd_i = h;
      sw_msg = m; sw_req = 1;
      tick;
      sw_req = 0;
      pc_i = ~p; a_i = ~a; sp_i = ~s;
      expect_entry(p, a, s, h, m, "sweep");
      tick;
      chk("R12 idle after entry", busy, 1'b0);
      chk("R4 qen after entry", qen, 1'b1);
      sp_i = 16'(s - 16'd2);
      do_return("sweep");
      chk("R7 qen after return", qen, 1'b0);
    end
    pc_i = P0; a_i = A0; sp_i = S0; hnd_i = H0;

    // R12 return ignored while busy
    sw_msg = 16'h00A1; sw_req = 1;
    tick;
    sw_req = 0; ret_req = 1;
    expect_entry(P0, A0, S0, H0, 16'h00A1, "R12 ret-while-busy");
    ret_req = 0;
    tick;
    chk("R12 return ignored, qen kept", qen, 1'b1);
    chk("R12 return ignored, idle", busy, 1'b0);

    // R5 queued while qen high, R11 same-cycle order
    sw_msg = 16'h00B1; sw_req = 1;
    tick;
    sw_req = 0;
    chk("R5 sw queued when qen high", busy, 1'b0);
    hw_msg = 16'h00B2; hw_req = 1;
    tick;
    hw_req = 0;
    chk("R5 hw queued", busy, 1'b0);
    sw_msg = 16'h00B3; hw_msg = 16'h00B4; sw_req = 1; hw_req = 1;
    tick;
    sw_req = 0; hw_req = 0;
    chk("R11 dual queued", busy, 1'b0);
    do_return("R5 pre-drain");
    qen_set = 1; qen_val = 1;
    tick;
    qen_set = 0;
    chk("R9 qen set", qen, 1'b1);
    exp_q[0] = 16'h00B1; exp_q[1] = 16'h00B2; exp_q[2] = 16'h00B3; exp_q[3] = 16'h00B4;
    drain(4, "R11 order");

    // R5 hw with queuing off still queued
    hw_msg = 16'h00C1; hw_req = 1;
    tick;
    hw_req = 0;
    chk("R5 hw not taken with qen low", busy, 1'b0);
    tick;
    chk("R5 hw still not taken", busy, 1'b0);
    exp_q[0] = 16'h00C1;
    drain(1, "R5 hw");

    // R2 zero handler drops requests
    hnd_i = '0;
    sw_msg = 16'h00D0; sw_req = 1;
    tick;
    sw_req = 0;
    chk("R2 sw dropped busy", busy, 1'b0);
    chk("R2 sw dropped qen", qen, 1'b0);
    hw_msg = 16'h00D1; hw_req = 1;
    tick;
    hw_req = 0;
    hnd_i = H0; boundary = 1;
    tick; tick;
    chk("R2 hw not queued", busy, 1'b0);
    boundary = 0;

    // R10 dispatch with zero handler discards
    qen_set = 1; qen_val = 1;
    tick;
    qen_set = 0;
    hw_msg = 16'h00E9; hw_req = 1;
    tick;
    hw_req = 0;
    hnd_i = '0; qen_set = 1; qen_val = 0;
    tick;
    qen_set = 0; boundary = 1;
    tick; tick;
    chk("R10 discarded no entry", busy, 1'b0);
    hnd_i = H0;
    tick; tick;
    chk("R10 message consumed", busy, 1'b0);
    chk("R10 qen stays low", qen, 1'b0);
    boundary = 0;

    // R8 overflow
    qen_set = 1; qen_val = 1;
    tick;
    qen_set = 0;
    for (int k = 0; k < CAPN; k++) begin
      exp_q[k] = 16'(16'h0E00 + k);
      hw_msg = exp_q[k]; hw_req = 1;
      tick;
      hw_req = 0;
      chk("R8 no overflow below capacity", ovf, 1'b0);
    end
    hw_msg = 16'h0EFF; hw_req = 1;
    tick;
    hw_req = 0;
    chk("R8 overflow flagged", ovf, 1'b1);
    tick;
    chk("R8 overflow sticky", ovf, 1'b1);
    drain(CAPN, "R8 preserved");
    chk("R8 overflow sticky after drain", ovf, 1'b1);
    rst_ni = 0;
    tick;
    rst_ni = 1;
    tick;
    chk("R8 overflow cleared by reset", ovf, 1'b0);
    chk("R1 qen after reset", qen, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule